// File: doc/BRIEF.md
# Narrow-Port Transfer Splitter

This block takes one bus transaction of 1 to 8 bytes and splits it into a series of beats, each sized to suit the port being addressed. The port can be 1, 2, 4 or 8 bytes wide. Two internal counters track the work that is left: the bytes remaining and the low five bits of the current address. For each beat the block presents a byte count and an address. When that beat is accepted, it subtracts the count from the remaining bytes and adds it to the address. The transaction ends when no bytes remain. Sizes 5, 6 and 7, and starts that are not aligned to the port width, are handled by the same per-beat rule as every other case. No beat is a fixed burst.

A controller starts the block with a one-cycle `start` pulse that carries the size, the low address and the port-width code. Beats leave through a valid/ready pair. While `beat_valid` is high, `beat_bytes` and `beat_addr` hold their values until the consumer raises `beat_ready`, so the consumer can apply back-pressure for any number of cycles. `beat_ready` has no effect while `beat_valid` is low. The `busy` and `done` pins are plain status signals. The counters stay inside the block and never drive any pin other than the beat outputs.

Top module: `beat_splitter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `beat_valid` and `done` are low. A reset in the middle of a transfer abandons that transfer.
- R2: A `start` in idle with a size of 1 to 8 raises `busy` and `beat_valid` in the next cycle. The first `beat_addr` equals `start_addr`.
- R3: Port code 0 means a 1-byte port, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. Each beat's `beat_bytes` is the largest of 1, 2, 4 or 8 that satisfies three limits: it is no more than the port width, no more than the bytes remaining, and `beat_addr` is a multiple of it.
- R4: A beat that has `beat_valid` and `beat_ready` high at a clock edge is consumed. The remaining count then drops by `beat_bytes`, and the address advances by `beat_bytes` modulo 32. A beat that is not consumed holds `beat_bytes` and `beat_addr` unchanged.
- R5: In the cycle after the beat that empties the count is consumed, `busy` and `beat_valid` are low and `done` is high. `done` is high for that one cycle only.
- R6: A `start` while `busy` is high is ignored, and the transfer in progress continues unchanged.
- R7: A `start` whose size is 0 or greater than 8 is ignored. `busy` and `done` stay low.
- R8: Sizes 5, 6 and 7 are split by the same rule as the other sizes. For example, 5 bytes at address 3 on a 4-byte port gives beats of 1 then 4. 7 bytes at address 1 on an 8-byte port gives 1, 2, 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transfer |
| start_size | input | 4 | Transfer size in bytes, valid from 1 to 8 |
| start_addr | input | 5 | Low five bits of the starting address |
| port_width | input | 2 | Port width code (0 = 1 byte, 3 = 8 bytes) |
| beat_valid | output | 1 | A beat is on offer |
| beat_ready | input | 1 | The consumer takes the offered beat |
| beat_bytes | output | 4 | Byte count of the offered beat |
| beat_addr | output | 5 | Low address of the offered beat |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The first beat is due one clock after `start`. Each later beat is due one clock after the consuming edge, and `done` rises one clock after the final consumption and falls the clock after that. The bench drives every input on the falling edge. It samples on the next falling edge, which is half a period after the edge that registered the change, so every result is read exactly one edge after its cause. Stall checks read the beat again one full cycle later, with `beat_ready` held low in between. The checks for an ignored start read `busy`, `beat_valid` and `done` over the two following cycles.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  // Port width code: the beat limit is 2**code bytes
  typedef enum logic [1:0] {
    PORT_X8  = 2'd0,
    PORT_X16 = 2'd1,
    PORT_X32 = 2'd2,
    PORT_X64 = 2'd3
  } port_code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } split_state_e;

endpackage

// File: rtl/bsplit_sizer.sv
module bsplit_sizer #(
  parameter int SIZE_W  = 4,
  parameter int ADDR_W  = 5,
  parameter int PORT_W  = 2,
  parameter int NUM_POW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SIZE_W-1:0] remaining,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] port,
  output logic [SIZE_W-1:0] bytes
);

  logic [NUM_POW-1:0] cand_ok;

  // One candidate per power of two, tested against all three limits
  for (genvar k = 0; k < NUM_POW; k++) begin : g_cand
    logic aligned;
    if (k == 0) begin : g_a0
      assign aligned = 1'b1;
    end else begin : g_an
      assign aligned = (addr[k-1:0] == '0);
    end
    assign cand_ok[k] = aligned && (int'(port) >= k) && (int'(remaining) >= (1 << k));
  end

  // Highest passing candidate wins
  always_comb begin
    bytes = SIZE_W'(1);
    for (int k = 0; k < NUM_POW; k++) begin
      if (cand_ok[k]) bytes = SIZE_W'(1 << k);
    end
  end

  // R3
  beat_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(bytes) == 1);

  // R3
  beat_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (int'(bytes) <= int'(remaining)) &&
           (int'(bytes) <= (1 << int'(port))) &&
           ((addr & ADDR_W'(bytes - SIZE_W'(1))) == '0));

endmodule

// File: rtl/bsplit_ctrl.sv
module bsplit_ctrl
  import bsplit_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int SIZE_W    = 4,
  parameter int ADDR_W    = 5,
  parameter int PORT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] start_size,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [PORT_W-1:0] start_port,
  input  logic              ack,
  input  logic [SIZE_W-1:0] beat_bytes,
  output logic [SIZE_W-1:0] rem,
  output logic [ADDR_W-1:0] addr,
  output logic [PORT_W-1:0] port,
  output logic              busy,
  output logic              done
);

  split_state_e      state_q;
  logic [SIZE_W-1:0] rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PORT_W-1:0] port_q;
  logic              done_q;
  logic              size_ok;
  logic              last_beat;

  assign size_ok   = (start_size != '0) && (int'(start_size) <= MAX_BYTES);
  assign last_beat = (beat_bytes == rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      port_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start && size_ok) begin
            state_q <= ST_RUN;
            rem_q   <= start_size;
            addr_q  <= start_addr;
            port_q  <= start_port;
          end
        end
        ST_RUN: begin
          if (ack) begin
            rem_q  <= rem_q - beat_bytes;
            addr_q <= addr_q + ADDR_W'(beat_bytes);
            if (last_beat) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem  = rem_q;
  assign addr = addr_q;
  assign port = port_q;
  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  // R4
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> $stable(rem_q) && $stable(addr_q) && $stable(port_q));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ack && !last_beat |=> busy && (rem_q == $past(rem_q) - $past(beat_bytes)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !ack |=> busy && $stable(addr_q));

  // R7
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !size_ok |=> !busy && !done);

endmodule

// File: rtl/beat_splitter.sv
module beat_splitter #(
  parameter int MAX_BYTES = 8,
  parameter int ADDR_W    = 5,
  parameter int SIZE_W    = $clog2(MAX_BYTES + 1),
  parameter int PORT_W    = $clog2($clog2(MAX_BYTES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] start_size,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [PORT_W-1:0] port_width,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [SIZE_W-1:0] beat_bytes,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              busy,
  output logic              done
);

  localparam int NUM_POW = $clog2(MAX_BYTES) + 1;

  logic [SIZE_W-1:0] rem;
  logic [ADDR_W-1:0] cur_addr;
  logic [PORT_W-1:0] cur_port;
  logic [SIZE_W-1:0] step;
  logic              run;
  logic              fire;

  assign fire = run && beat_ready;

  bsplit_ctrl #(
    .MAX_BYTES (MAX_BYTES),
    .SIZE_W    (SIZE_W),
    .ADDR_W    (ADDR_W),
    .PORT_W    (PORT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_size (start_size),
    .start_addr (start_addr),
    .start_port (port_width),
    .ack        (fire),
    .beat_bytes (step),
    .rem        (rem),
    .addr       (cur_addr),
    .port       (cur_port),
    .busy       (run),
    .done       (done)
  );

  bsplit_sizer #(
    .SIZE_W  (SIZE_W),
    .ADDR_W  (ADDR_W),
    .PORT_W  (PORT_W),
    .NUM_POW (NUM_POW)
  ) u_sizer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (run),
    .remaining (rem),
    .addr      (cur_addr),
    .port      (cur_port),
    .bytes     (step)
  );

  assign beat_valid = run;
  assign beat_bytes = step;
  assign beat_addr  = cur_addr;
  assign busy       = run;

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (start_size != '0) && (int'(start_size) <= MAX_BYTES)
      |=> beat_valid && (beat_addr == $past(start_addr)));

  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_bytes) && $stable(beat_addr));

endmodule

// File: tb/beat_splitter_test.sv
module beat_splitter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] start_size = '0;
  logic [4:0] start_addr = '0;
  logic [1:0] port_width = '0;
  logic       beat_ready = 1'b0;
  logic       beat_valid;
  logic [3:0] beat_bytes;
  logic [4:0] beat_addr;
  logic       busy;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  beat_splitter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_size (start_size),
    .start_addr (start_addr),
    .port_width (port_width),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_bytes (beat_bytes),
    .beat_addr  (beat_addr),
    .busy       (busy),
    .done       (done)
  );

  // Directed vectors: {size, addr, port, beats, first, second}
  localparam logic [22:0] VEC [8] = '{
    {4'd5, 5'd3,  2'd2, 4'd2, 4'd1, 4'd4},
    {4'd6, 5'd2,  2'd1, 4'd3, 4'd2, 4'd2},
    {4'd7, 5'd1,  2'd3, 4'd3, 4'd1, 4'd2},
    {4'd8, 5'd0,  2'd0, 4'd8, 4'd1, 4'd1},
    {4'd8, 5'd0,  2'd3, 4'd1, 4'd8, 4'd0},
    {4'd8, 5'd0,  2'd2, 4'd2, 4'd4, 4'd4},
    {4'd3, 5'd1,  2'd1, 4'd2, 4'd1, 4'd2},
    {4'd4, 5'd30, 2'd3, 4'd2, 4'd2, 4'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Beat rule from R3: largest power of two within port, remaining and alignment
  function automatic int ref_bytes(input int rem, input int a, input int pw);
    for (int p = 8; p >= 1; p = p / 2) begin
      if (p <= (1 << pw) && p <= rem && (a % p) == 0) return p;
    end
    return 1;
  endfunction

  task automatic run_xfer(input int sz, input int ad, input int pw,
                          input bit stall, input bit inject,
                          output int nb, output int b0, output int b1);
    int rem;
    int a;
    int eb;
    rem = sz; a = ad; nb = 0; b0 = 0; b1 = 0;
    start = 1'b1; start_size = 4'(sz); start_addr = 5'(ad); port_width = 2'(pw);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && beat_valid === 1'b1, "R2 launch", int'(busy), 1);
    chk(beat_addr === 5'(ad), "R2 first addr", int'(beat_addr), ad);
    while (rem > 0 && nb < 16) begin
      eb = ref_bytes(rem, a, pw);
      chk(beat_bytes === 4'(eb), "R3 beat size", int'(beat_bytes), eb);
      chk(beat_addr === 5'(a), "R4 beat addr", int'(beat_addr), a);
      if (nb == 0) b0 = int'(beat_bytes);
      if (nb == 1) b1 = int'(beat_bytes);
      if (inject) begin
        // R6: start while busy must be ignored
        start = 1'b1; start_size = 4'd1; start_addr = 5'(a ^ 1); port_width = 2'd0;
      end
      if (stall) begin
        @(negedge clk);
        chk(beat_valid === 1'b1 && beat_bytes === 4'(eb) && beat_addr === 5'(a),
            "R4 stall hold", int'(beat_addr), a);
      end
      beat_ready = 1'b1;
      @(negedge clk);
      beat_ready = 1'b0;
      start = 1'b0;
      rem = rem - eb;
      a = (a + eb) % 32;
      nb++;
    end
    chk(done === 1'b1 && busy === 1'b0 && beat_valid === 1'b0, "R5 done rise", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R5 done single", int'(done), 0);
  endtask

  task automatic bad_start(input int sz);
    start = 1'b1; start_size = 4'(sz); start_addr = 5'd4; port_width = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0 && beat_valid === 1'b0, "R7 bad size busy", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 bad size done", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nb;
    int b0;
    int b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && beat_valid === 1'b0 && done === 1'b0, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && beat_valid === 1'b0 && done === 1'b0, "R1 after reset", int'(busy), 0);

    // Directed table (R8 extended sizes among them)
    for (int i = 0; i < 8; i++) begin
      run_xfer(int'(VEC[i][22:19]), int'(VEC[i][18:14]), int'(VEC[i][13:12]),
               i[0], 1'b0, nb, b0, b1);
      chk(nb == int'(VEC[i][11:8]), "R8 beat count", nb, int'(VEC[i][11:8]));
      chk(b0 == int'(VEC[i][7:4]), "R8 first beat", b0, int'(VEC[i][7:4]));
      if (nb > 1) chk(b1 == int'(VEC[i][3:0]), "R8 second beat", b1, int'(VEC[i][3:0]));
    end

    // Full sweep: all sizes, low addresses and port widths
    for (int sz = 1; sz <= 8; sz++)
      for (int ad = 0; ad < 32; ad++)
        for (int pw = 0; pw < 4; pw++)
          run_xfer(sz, ad, pw, (ad % 3) == 0, (ad % 5) == 1, nb, b0, b1);

    // R7: invalid sizes
    bad_start(0);
    bad_start(9);
    bad_start(15);

    // R4: ready without valid has no effect
    beat_ready = 1'b1;
    @(negedge clk);
    beat_ready = 1'b0;
    chk(busy === 1'b0 && done === 1'b0, "R4 idle ready", int'(busy), 0);

    // R1: reset in the middle of a transfer
    start = 1'b1; start_size = 4'd8; start_addr = 5'd0; port_width = 2'd0;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && beat_valid === 1'b0 && done === 1'b0, "R1 mid reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset abandons", int'(busy), 0);
    run_xfer(2, 1, 3, 1'b0, 1'b0, nb, b0, b1);
    chk(nb == 2, "R3 misaligned pair", nb, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule